// File: doc/BRIEF.md
# Serialized Interrupt Request Agent

This block is the peripheral side of a serialized interrupt bus. It shares a single active-low, open-drain wire and the bus clock with a host controller. The host opens each cycle with a start frame, which is a low pulse on the wire. A fixed series of three-clock data frames follows, one per interrupt channel. The agent recognises the start pulse and then counts clocks to keep track of which frame is on the wire. In the frame that belongs to a pending local interrupt, it pulls the wire low for one clock, actively drives it high for the next clock, and then lets it float. Once the last frame has passed, it waits for the host's stop frame. It then idles until the next start frame arrives.

The wire is sampled on the rising clock edge. The agent presents two drive enables: a low-side pull and a high-side pull. An external open-drain pad turns them into the wire level. The request inputs are captured once per cycle, on the clock edge that ends the start pulse.

The sequencer has seven states. `ST_IDLE` waits for the wire to go low. `ST_START` measures the low run. `ST_START_TA` is the start frame's turnaround clock. `ST_SAMPLE`, `ST_RECOVER` and `ST_TURN` are the three phases of a data frame. `ST_STOP` waits for the stop frame. The transitions are:
- idle-to-start: the wire is sampled low.
- start-accept: the wire returns high after a run of 4 to 8 low clocks.
- start-reject: the wire returns high after a run of any other length.
- turnaround-to-sample.
- sample-to-recover.
- recover-to-turn.
- turn-to-next-sample: more frames remain.
- turn-to-stop: the last frame has ended.
- stop-accept: the wire returns high after 2 or more low clocks.

Top module: `sirq_agent`

## Requirements
- R1: While `rst_n` is low, and until a valid start frame is seen afterwards, `drive_low` and `drive_high` are both 0. An asynchronous reset returns the sequencer to `ST_IDLE` and clears the frame counter.
- R2: A start frame is a run of 4 to 8 consecutive low samples followed by a high sample. Runs of 3 or fewer, and runs of 9 or more, start nothing, and no frame is driven afterwards.
- R3: Let clock 0 be the first clock in which the wire is high after a valid start run. The sample phase of frame f then falls in clock 2+3f, the recovery phase in clock 3+3f and the turnaround phase in clock 4+3f. There are 17 frames, f = 0..16.
- R4: `req_in` bit f belongs to frame f. Bits 0 to 15 are interrupt channels 0 to 15, and bit 16 is the channel-check frame. A captured 1 drives `drive_low` high for exactly the sample clock of that frame.
- R5: After driving a sample, the agent asserts `drive_high` for the single following clock (recovery), then deasserts both in the turnaround clock.
- R6: For a frame whose captured request bit is 0, both enables stay 0 for all three of its clocks.
- R7: `drive_low` and `drive_high` are never 1 at the same time.
- R8: `req_in` is captured on the edge that accepts the start frame. Changes to `req_in` later in the cycle do not alter that cycle's drive pattern.
- R9: After the last frame's turnaround, a low run of 2 or more clocks followed by a high sample ends the cycle. A single low clock does not end it. A low run of 4 or more seen while waiting for the stop is taken as the stop, not as a new start.
- R10: Between a stop frame and the next valid start frame, low pulses on the wire never cause either enable to rise.
- R11: A reset asserted in the middle of a cycle drops both enables at once. No frame is driven until a new valid start frame arrives.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock; the wire is sampled on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_in | input | 1 | Sampled level of the shared interrupt wire (1 = high) |
| req_in | input | NUM_FRAMES | Local request per frame; bit f maps to frame f |
| drive_low | output | 1 | Pull the wire low (sample phase of an owned frame) |
| drive_high | output | 1 | Drive the wire high (recovery phase of an owned frame) |

## Verification
A wrong frame count or phase moves the owned pull into a neighbouring clock. This shows at the enables within one frame, three clocks, of the first owned frame after the error. A sequencer stuck outside `ST_IDLE`/`ST_STOP` keeps counting frames after a stop or an invalid start. It therefore drives in a cycle where the host sent no valid start, and this shows within 2+3f clocks for the lowest requested frame f. A wrong request capture shows as a pattern that follows the live `req_in` instead of the captured one from the first changed frame on.

// File: rtl/sirq_pkg.sv
package sirq_pkg;

    // Default frame plan: 16 interrupt channels plus one channel-check frame
    localparam int SIRQ_FRAMES    = 17;
    localparam int SIRQ_START_MIN = 4;
    localparam int SIRQ_START_MAX = 8;
    localparam int SIRQ_STOP_MIN  = 2;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_START_TA,
        ST_SAMPLE,
        ST_RECOVER,
        ST_TURN,
        ST_STOP
    } sirq_state_e;

endpackage

// File: rtl/sirq_low_run.sv
// Counts consecutive low samples of the wire, saturating one above the
// longest legal start pulse so that overlong runs stay distinguishable.
module sirq_low_run #(
    parameter int RUN_W   = 4,
    parameter int RUN_SAT = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bus_in,
    output logic [RUN_W-1:0] run_len
);

    localparam logic [RUN_W-1:0] SAT_V = RUN_W'(RUN_SAT);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            run_len <= '0;
        end else if (bus_in) begin
            run_len <= '0;
        end else if (run_len != SAT_V) begin
            run_len <= run_len + 1'b1;
        end
    end

    // run length never exceeds the saturation value
    sat_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        run_len <= SAT_V);

endmodule

// File: rtl/sirq_frame_seq.sv
// Cycle sequencer: start recognition, frame/phase tracking, stop detection.
module sirq_frame_seq
    import sirq_pkg::*;
#(
    parameter int NUM_FRAMES = SIRQ_FRAMES,
    parameter int START_MIN  = SIRQ_START_MIN,
    parameter int START_MAX  = SIRQ_START_MAX,
    parameter int STOP_MIN   = SIRQ_STOP_MIN,
    parameter int RUN_W      = 4,
    parameter int FRM_W      = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bus_in,
    input  logic [RUN_W-1:0] run_len,
    output logic             in_sample,
    output logic             in_recover,
    output logic [FRM_W-1:0] frame_idx,
    output logic             capture
);

    localparam logic [RUN_W-1:0] RUN_MIN_V  = RUN_W'(START_MIN);
    localparam logic [RUN_W-1:0] RUN_MAX_V  = RUN_W'(START_MAX);
    localparam logic [RUN_W-1:0] STOP_MIN_V = RUN_W'(STOP_MIN);
    localparam logic [FRM_W-1:0] LAST_FRM   = FRM_W'(NUM_FRAMES - 1);

    sirq_state_e      state, state_nx;
    logic [FRM_W-1:0] frame_nx;
    logic             start_ok;
    logic             stop_ok;

    assign start_ok = bus_in && (run_len >= RUN_MIN_V) && (run_len <= RUN_MAX_V);
    assign stop_ok  = bus_in && (run_len >= STOP_MIN_V);

    // next-state and frame counter
    always_comb begin
        state_nx = state;
        frame_nx = frame_idx;
        unique case (state)
            ST_IDLE: begin
                frame_nx = '0;
                if (!bus_in) state_nx = ST_START;
            end
            ST_START: begin
                if (start_ok)    state_nx = ST_START_TA;
                else if (bus_in) state_nx = ST_IDLE;
            end
            ST_START_TA: begin
                state_nx = ST_SAMPLE;
                frame_nx = '0;
            end
            ST_SAMPLE:  state_nx = ST_RECOVER;
            ST_RECOVER: state_nx = ST_TURN;
            ST_TURN: begin
                if (frame_idx == LAST_FRM) begin
                    state_nx = ST_STOP;
                end else begin
                    state_nx = ST_SAMPLE;
                    frame_nx = frame_idx + 1'b1;
                end
            end
            ST_STOP: begin
                if (stop_ok) state_nx = ST_IDLE;
            end
            default: state_nx = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            frame_idx <= '0;
        end else begin
            state     <= state_nx;
            frame_idx <= frame_nx;
        end
    end

    // outputs
    always_comb begin
        in_sample  = (state == ST_SAMPLE);
        in_recover = (state == ST_RECOVER);
        capture    = (state == ST_START) && start_ok;
    end

    // R3
    frame_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        frame_idx <= LAST_FRM);

    // R3
    frame_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_TURN && frame_idx != LAST_FRM)
        |=> (state == ST_SAMPLE && frame_idx == $past(frame_idx) + 1'b1));

    // R2
    first_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
        capture |=> (state == ST_START_TA));

    // R9
    stop_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_STOP && bus_in && run_len >= STOP_MIN_V) |=> (state == ST_IDLE));

endmodule

// File: rtl/sirq_drive.sv
// Request capture and per-frame enable generation.
module sirq_drive #(
    parameter int NUM_FRAMES = 17,
    parameter int FRM_W      = 5
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  capture,
    input  logic [NUM_FRAMES-1:0] req_in,
    input  logic                  in_sample,
    input  logic                  in_recover,
    input  logic [FRM_W-1:0]      frame_idx,
    output logic                  drive_low,
    output logic                  drive_high
);

    logic [NUM_FRAMES-1:0] req_lat;
    logic                  own_frame;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       req_lat <= '0;
        else if (capture) req_lat <= req_in;
    end

    always_comb begin
        own_frame = 1'b0;
        for (int i = 0; i < NUM_FRAMES; i++) begin
            if (frame_idx == FRM_W'(i)) own_frame = req_lat[i];
        end
    end

    assign drive_low  = in_sample  && own_frame;
    assign drive_high = in_recover && own_frame;

    // R7
    drive_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(drive_low && drive_high));

    // R5
    recover_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        drive_low |=> drive_high);

    // R5
    recover_owner_chk: assert property (@(posedge clk) disable iff (!rst_n)
        drive_high |-> $past(drive_low));

    // R5
    turn_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        drive_high |=> (!drive_low && !drive_high));

endmodule

// File: rtl/sirq_agent.sv
module sirq_agent
    import sirq_pkg::*;
#(
    parameter int NUM_FRAMES = SIRQ_FRAMES,
    parameter int START_MIN  = SIRQ_START_MIN,
    parameter int START_MAX  = SIRQ_START_MAX,
    parameter int STOP_MIN   = SIRQ_STOP_MIN
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  bus_in,
    input  logic [NUM_FRAMES-1:0] req_in,
    output logic                  drive_low,
    output logic                  drive_high
);

    localparam int RUN_SAT = START_MAX + 1;
    localparam int RUN_W   = $clog2(RUN_SAT + 1);
    localparam int FRM_W   = (NUM_FRAMES > 1) ? $clog2(NUM_FRAMES) : 1;

    logic [RUN_W-1:0] run_len;
    logic             in_sample;
    logic             in_recover;
    logic [FRM_W-1:0] frame_idx;
    logic             capture;

    sirq_low_run #(
        .RUN_W   (RUN_W),
        .RUN_SAT (RUN_SAT)
    ) u_run (
        .clk     (clk),
        .rst_n   (rst_n),
        .bus_in  (bus_in),
        .run_len (run_len)
    );

    sirq_frame_seq #(
        .NUM_FRAMES (NUM_FRAMES),
        .START_MIN  (START_MIN),
        .START_MAX  (START_MAX),
        .STOP_MIN   (STOP_MIN),
        .RUN_W      (RUN_W),
        .FRM_W      (FRM_W)
    ) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .bus_in     (bus_in),
        .run_len    (run_len),
        .in_sample  (in_sample),
        .in_recover (in_recover),
        .frame_idx  (frame_idx),
        .capture    (capture)
    );

    sirq_drive #(
        .NUM_FRAMES (NUM_FRAMES),
        .FRM_W      (FRM_W)
    ) u_drv (
        .clk        (clk),
        .rst_n      (rst_n),
        .capture    (capture),
        .req_in     (req_in),
        .in_sample  (in_sample),
        .in_recover (in_recover),
        .frame_idx  (frame_idx),
        .drive_low  (drive_low),
        .drive_high (drive_high)
    );

    // R1
    reset_quiet_chk: assert property (@(posedge clk)
        !rst_n |-> (!drive_low && !drive_high));

endmodule

// File: tb/sirq_agent_test.sv
`timescale 1ns/1ps
module sirq_agent_test;

    localparam int NF = 17;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          host_low = 1'b0;
    logic [NF-1:0] req_in = '1;
    logic          drive_low;
    logic          drive_high;
    logic          bus_line;

    int checks = 0;
    int failures = 0;
    int cyc = 0;
    bit done = 0;

    logic  exp_lo_q[$];
    logic  exp_hi_q[$];
    string tag_q[$];

    always #5 clk = ~clk;

    // open-drain wire with pull-up
    assign bus_line = !(host_low || drive_low);

    sirq_agent uut (
        .clk        (clk),
        .rst_n      (rst_n),
        .bus_in     (bus_line),
        .req_in     (req_in),
        .drive_low  (drive_low),
        .drive_high (drive_high)
    );

    // monitor: pops one expected item per clock and compares
    always @(negedge clk) begin
        checks++;
        if (drive_low && drive_high) begin
            failures++;
            $display("FAIL R7 both enables actual=%b%b expected=not 11", drive_low, drive_high);
        end
        if (exp_lo_q.size() > 0) begin
            logic  elo, ehi;
            string t;
            elo = exp_lo_q.pop_front();
            ehi = exp_hi_q.pop_front();
            t   = tag_q.pop_front();
            checks++;
            if (drive_low !== elo || drive_high !== ehi) begin
                failures++;
                $display("FAIL %s at t=%0t actual lo/hi=%b/%b expected=%b/%b",
                         t, $time, drive_low, drive_high, elo, ehi);
            end
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000 && !done) begin
            failures++;
            checks++;
            $display("FAIL R1 watchdog expired actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    // driver: one clock of host stimulus plus the expected enables for it
    task automatic step(input logic hlow, input logic rstv,
                        input logic elo, input logic ehi, input string tag);
        @(posedge clk);
        #2;
        rst_n    = rstv;
        host_low = hlow;
        exp_lo_q.push_back(elo);
        exp_hi_q.push_back(ehi);
        tag_q.push_back(tag);
    endtask

    task automatic send_start(input int len, input string tag);
        for (int i = 0; i < len; i++) step(1'b1, 1'b1, 1'b0, 1'b0, tag);
        step(1'b0, 1'b1, 1'b0, 1'b0, tag);
    endtask

    // frames after the start; clock j counted from the first high clock
    task automatic frames(input bit valid, input logic [NF-1:0] req,
                          input int flip_at, input int reset_at, input string tag);
        for (int j = 1; j <= 3*NF + 1; j++) begin
            int   f, ph;
            logic elo, ehi, rv;
            bit   live;
            if (flip_at > 0 && j == flip_at) req_in = ~req_in;
            rv   = !(reset_at > 0 && (j == reset_at || j == reset_at + 1));
            live = valid && !(reset_at > 0 && j >= reset_at);
            f    = (j - 2) / 3;
            ph   = (j - 2) % 3;
            elo  = live && j >= 2 && ph == 0 && req[f];
            ehi  = live && j >= 2 && ph == 1 && req[f];
            step(1'b0, rv, elo, ehi, tag);
        end
    endtask

    task automatic stop_frame(input int len, input string tag);
        for (int i = 0; i < len; i++) step(1'b1, 1'b1, 1'b0, 1'b0, tag);
        step(1'b0, 1'b1, 1'b0, 1'b0, tag);
    endtask

    initial begin
        // R1: reset with all requests pending
        for (int i = 0; i < 4; i++) step(1'b0, 1'b0, 1'b0, 1'b0, "R1 reset");
        for (int i = 0; i < 4; i++) step(1'b0, 1'b1, 1'b0, 1'b0, "R1 idle");

        // R3/R4: shortest start, sparse requests incl. channel-check frame
        req_in = 17'h10005;
        send_start(4, "R2 start4");
        frames(1'b1, 17'h10005, 0, 0, "R4 sparse");
        stop_frame(2, "R9 stop2");

        // R8: longest start, requests flipped mid-cycle
        req_in = 17'h0AAAA;
        send_start(8, "R2 start8");
        frames(1'b1, 17'h0AAAA, 5, 0, "R8 flip");
        stop_frame(3, "R9 stop3");

        // R2: too-short and too-long start runs
        req_in = '1;
        send_start(3, "R2 short");
        frames(1'b0, '1, 0, 0, "R2 short run");
        send_start(9, "R2 long");
        frames(1'b0, '1, 0, 0, "R2 long run");
        step(1'b0, 1'b1, 1'b0, 1'b0, "R2 gap");

        // R5/R9: all requests, single-low not a stop, 4-low taken as stop
        req_in = '1;
        send_start(5, "R2 start5");
        frames(1'b1, '1, 0, 0, "R5 all");
        stop_frame(1, "R9 single low");
        step(1'b0, 1'b1, 1'b0, 1'b0, "R9 wait");
        stop_frame(4, "R9 long stop");
        frames(1'b0, '1, 0, 0, "R9 no restart");

        // R10: pulses after stop never drive
        for (int i = 0; i < 5; i++) begin
            step(1'b1, 1'b1, 1'b0, 1'b0, "R10 pulse");
            step(1'b0, 1'b1, 1'b0, 1'b0, "R10 pulse");
        end

        // R6/R11: reset in mid-cycle
        req_in = 17'h00F0F;
        send_start(6, "R2 start6");
        frames(1'b1, 17'h00F0F, 0, 20, "R11 mid reset R6");
        stop_frame(2, "R11 after reset");

        // R3: recovery after reset, first and last frame
        req_in = 17'h10001;
        send_start(4, "R2 start4b");
        frames(1'b1, 17'h10001, 0, 0, "R3 ends");
        stop_frame(2, "R9 final stop");

        step(1'b0, 1'b1, 1'b0, 1'b0, "R10 tail");
        @(negedge clk);
        #1;
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule